// File: doc/BRIEF.md
# Noise-Shaped Phase Truncation Synthesizer

This block is the digital core of a direct digital frequency synthesizer. A 16-bit phase register advances by a frequency word on every enabled clock and wraps around the phase circle. The top 12 bits of that phase are not simply cut down to a table address. A single fourth-order error-feedback loop requantizes them to 8 bits. The truncation error is therefore pushed toward high frequencies, where a later reconstruction filter can remove it.

The 8-bit shaped phase addresses a sine table that holds one full period of two's-complement samples. Each enabled input sample produces one registered output. The output carries the signed amplitude, the table address used, and a valid flag. The table is 16 times smaller than one addressed by the full 12-bit phase.

Top module: `nsdds_core`

## Requirements
- R1: Synchronous reset (`rst` high at a rising edge) clears the phase register and all four error registers, and drops `amp_valid`. The first sample taken after reset therefore has phase 0, and it comes out with `phase_out` = 0 and `amp_out` = 0.
- R2: Each enabled cycle takes the current phase register as the sample and then adds `fcw` to it modulo 2^16. Sample n of a run with a constant word is n·`fcw` mod 65536. Its upper 12 bits (bits 15..4) form the shaper input x, and bits 3..0 are dropped.
- R3: The shaper forms v = x + 4·e1 − 6·e2 + 4·e3 − e4, where e1..e4 are the four most recent stored errors, e1 being the newest. It outputs `phase_out` = floor(v/16) mod 256 and stores the new error v − 16·floor(v/16), which always lies in 0..15. v always stays within −105..4215.
- R4: Over a long run, the mean of the wrapped difference 16·`phase_out` − x stays within a quarter of one 12-bit phase LSB.
- R5: For every sample, the wrapped difference 16·`phase_out` − x lies within −120..+120.
- R6: `amp_out` is a signed two's-complement word within ±1 of round(2047·sin(2π·`phase_out`/256)), and it never leaves −2047..2047.
- R7: An enabled cycle at rising edge k gives `amp_valid` high for exactly one cycle, after edge k+2. Cycles with `en` low produce no output and leave the phase register and the error registers unchanged. Outputs appear in the order of their inputs.
- R8: With `fcw` = 0 from reset, every output has `phase_out` = 0 and `amp_out` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Takes one phase sample and advances the phase this cycle |
| fcw | input | 16 | Frequency word added to the phase register |
| amp_out | output | 12 | Signed sine amplitude |
| phase_out | output | 8 | Noise-shaped table address that goes with `amp_out` |
| amp_valid | output | 1 | `amp_out` and `phase_out` hold a new sample |

## Verification
A cycle-accurate reference loop in the bench predicts every shaped address. Wrong feedback signs, swapped error taps or a missing tap therefore show up as address mismatches within a few samples. A loop that only truncates passes the instantaneous-error bound but shows a steady mean offset, so the long mean test catches it. Frequency words close to 2^16 and at 2^15+1 test the modulo wrap of the phase register. Words of 0 and 16 test the zero-phase start and a step of exactly one LSB. Single enable pulses and gaps in the enable pattern show whether the output comes too early or too late, and whether the loop state drifts while idle.

// File: rtl/nsdds_pkg.sv
package nsdds_pkg;

    // pi scaled by 2^28, used by the elaboration-time sine evaluator
    localparam longint PI_Q28 = 64'sd843314857;

    function automatic int binom(input int n, input int k);
        int r;
        r = 1;
        for (int i = 1; i <= k; i++) begin
            r = (r * (n - k + i)) / i;
        end
        return r;
    endfunction

    // feedback weight on the k-th delayed error for NTF (1 - z^-1)^order
    function automatic int ntf_coef(input int order, input int k);
        int c;
        c = binom(order, k);
        return ((k % 2) == 1) ? c : -c;
    endfunction

    // sum of feedback weights of one sign (pos=1 positive, pos=0 magnitude of negative)
    function automatic int ntf_weight_sum(input int order, input bit pos);
        int s;
        s = 0;
        for (int k = 1; k <= order; k++) begin
            if (pos && ntf_coef(order, k) > 0) s += ntf_coef(order, k);
            if (!pos && ntf_coef(order, k) < 0) s -= ntf_coef(order, k);
        end
        return s;
    endfunction

    // round(scale * sin(2*pi*q/depth)) for q in the first quarter, integer Taylor series
    function automatic int quarter_sine(input int q, input int depth, input int scale);
        longint x;
        longint term;
        longint acc;
        x    = (2 * PI_Q28 * longint'(q)) / longint'(depth);
        term = x;
        acc  = x;
        for (int n = 1; n <= 7; n++) begin
            term = (term * x) >>> 28;
            term = (term * x) >>> 28;
            term = -term / longint'((2 * n) * (2 * n + 1));
            acc  = acc + term;
        end
        return int'((acc * longint'(scale) + (64'sd1 <<< 27)) >>> 28);
    endfunction

    // full-period sine point built from quarter-wave symmetry
    function automatic int sine_point(input int idx, input int depth, input int scale);
        int quarter;
        int q;
        int mag;
        quarter = depth / 4;
        q       = idx % quarter;
        case (idx / quarter)
            0:       mag = quarter_sine(q, depth, scale);
            1:       mag = quarter_sine(quarter - q, depth, scale);
            2:       mag = -quarter_sine(q, depth, scale);
            default: mag = -quarter_sine(quarter - q, depth, scale);
        endcase
        return mag;
    endfunction

endpackage

// File: rtl/nsdds_phase_acc.sv
module nsdds_phase_acc #(
    parameter int ACC_W = 16,
    parameter int PH_W  = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [ACC_W-1:0] fcw,
    output logic [PH_W-1:0]  ph_out,
    output logic             ph_valid
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [PH_W-1:0]  ph;
        logic             vld;
    } acc_state_t;

    acc_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = en;
        if (en) begin
            st_d.ph  = st_q.acc[ACC_W-1 -: PH_W];
            st_d.acc = st_q.acc + fcw;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ph_out   = st_q.ph;
    assign ph_valid = st_q.vld;

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(st_q.acc)); // R7

    AST_PH_STEADY: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(ph_out)); // R7

endmodule

// File: rtl/nsdds_shaper.sv
module nsdds_shaper
    import nsdds_pkg::*;
#(
    parameter int PH_W   = 12,
    parameter int ADDR_W = 8,
    parameter int ORDER  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vld_in,
    input  logic [PH_W-1:0]   ph_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              vld_out
);

    localparam int DROP      = PH_W - ADDR_W;
    localparam int EMAX      = (1 << DROP) - 1;
    localparam int FB_POS    = ntf_weight_sum(ORDER, 1'b1) * EMAX;
    localparam int FB_NEG    = ntf_weight_sum(ORDER, 1'b0) * EMAX;
    localparam int V_MAX     = (1 << PH_W) - 1 + FB_POS;
    localparam int V_MIN     = -FB_NEG;
    localparam int ERR_BOUND = (1 << (ORDER - 1)) * EMAX;

    typedef struct packed {
        logic [ORDER-1:0][DROP-1:0] err;
        logic [ADDR_W-1:0]          addr;
        logic                       vld;
    } shp_state_t;

    shp_state_t st_d, st_q;
    int         v_mon;
    int         perr_mon;

    always_comb begin
        int fb;
        int v;
        int y;
        fb = 0;
        for (int k = 1; k <= ORDER; k++) begin
            fb += ntf_coef(ORDER, k) * int'(st_q.err[k-1]);
        end
        v        = int'(ph_in) + fb;
        y        = v >>> DROP;
        v_mon    = v;
        perr_mon = y * (1 << DROP) - int'(ph_in);

        st_d     = st_q;
        st_d.vld = vld_in;
        if (vld_in) begin
            st_d.addr   = ADDR_W'(y);
            st_d.err[0] = DROP'(v);
            for (int k = 1; k < ORDER; k++) begin
                st_d.err[k] = st_q.err[k-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign addr_out = st_q.addr;
    assign vld_out  = st_q.vld;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        vld_in |-> (v_mon >= V_MIN && v_mon <= V_MAX)); // R3

    AST_ERR_BOUND: assert property (@(posedge clk) disable iff (rst)
        vld_in |-> (perr_mon >= -ERR_BOUND && perr_mon <= ERR_BOUND)); // R5

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !vld_in |=> $stable(st_q.err)); // R7

    AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (vld_in && ph_in == '0 && st_q.err == '0) |=> (addr_out == '0)); // R8

endmodule

// File: rtl/nsdds_sine_rom.sv
module nsdds_sine_rom
    import nsdds_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int AMP_W   = 12,
    parameter int AMP_MAX = 2047
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    vld_in,
    input  logic [ADDR_W-1:0]       addr_in,
    output logic signed [AMP_W-1:0] amp_out,
    output logic [ADDR_W-1:0]       addr_out,
    output logic                    vld_out
);

    localparam int DEPTH = 1 << ADDR_W;

    logic signed [AMP_W-1:0] tbl [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign tbl[g] = AMP_W'(sine_point(g, DEPTH, AMP_MAX));
    end

    typedef struct packed {
        logic signed [AMP_W-1:0] amp;
        logic [ADDR_W-1:0]       addr;
        logic                    vld;
    } rom_state_t;

    rom_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_in;
        if (vld_in) begin
            st_d.amp  = tbl[addr_in];
            st_d.addr = addr_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign amp_out  = st_q.amp;
    assign addr_out = st_q.addr;
    assign vld_out  = st_q.vld;

    AST_AMP_RANGE: assert property (@(posedge clk) disable iff (rst)
        vld_out |-> (int'(amp_out) >= -AMP_MAX && int'(amp_out) <= AMP_MAX)); // R6

    AST_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
        (vld_out && addr_out == '0) |-> (amp_out == '0)); // R6

endmodule

// File: rtl/nsdds_core.sv
module nsdds_core #(
    parameter int ACC_W   = 16,
    parameter int PH_W    = 12,
    parameter int ADDR_W  = 8,
    parameter int AMP_W   = 12,
    parameter int AMP_MAX = 2047,
    parameter int ORDER   = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic [ACC_W-1:0]        fcw,
    output logic signed [AMP_W-1:0] amp_out,
    output logic [ADDR_W-1:0]       phase_out,
    output logic                    amp_valid
);

    logic [PH_W-1:0]   ph_s1;
    logic              vld_s1;
    logic [ADDR_W-1:0] addr_s2;
    logic              vld_s2;

    nsdds_phase_acc #(
        .ACC_W (ACC_W),
        .PH_W  (PH_W)
    ) u_acc (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .fcw      (fcw),
        .ph_out   (ph_s1),
        .ph_valid (vld_s1)
    );

    nsdds_shaper #(
        .PH_W   (PH_W),
        .ADDR_W (ADDR_W),
        .ORDER  (ORDER)
    ) u_shaper (
        .clk      (clk),
        .rst      (rst),
        .vld_in   (vld_s1),
        .ph_in    (ph_s1),
        .addr_out (addr_s2),
        .vld_out  (vld_s2)
    );

    nsdds_sine_rom #(
        .ADDR_W  (ADDR_W),
        .AMP_W   (AMP_W),
        .AMP_MAX (AMP_MAX)
    ) u_rom (
        .clk      (clk),
        .rst      (rst),
        .vld_in   (vld_s2),
        .addr_in  (addr_s2),
        .amp_out  (amp_out),
        .addr_out (phase_out),
        .vld_out  (amp_valid)
    );

    AST_VALID_CHAIN: assert property (@(posedge clk) disable iff (rst)
        vld_s2 |=> amp_valid); // R7

    AST_VALID_GAP: assert property (@(posedge clk) disable iff (rst)
        !vld_s2 |=> !amp_valid); // R7

    AST_ADDR_PASS: assert property (@(posedge clk) disable iff (rst)
        vld_s2 |=> (phase_out == $past(addr_s2))); // R6

endmodule

// File: tb/tb_nsdds_core.sv
module tb_nsdds_core;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               en  = 1'b0;
    logic [15:0]        fcw = '0;
    logic signed [11:0] amp_out;
    logic [7:0]         phase_out;
    logic               amp_valid;

    always #2.5 clk = ~clk;

    nsdds_core dut (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .fcw       (fcw),
        .amp_out   (amp_out),
        .phase_out (phase_out),
        .amp_valid (amp_valid)
    );

    typedef struct {
        int    addr;
        int    x;
        string tag;
    } exp_t;

    exp_t   sb[$];
    int     checks   = 0;
    int     failures = 0;
    int     m_acc    = 0;
    int     m_err[4] = '{0, 0, 0, 0};
    bit     track_mean = 1'b0;
    longint mean_sum = 0;
    int     mean_n   = 0;
    bit     done     = 1'b0;
    int     cyc      = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int ref_amp(input int a);
        real s;
        s = 2047.0 * $sin(2.0 * 3.14159265358979 * real'(a) / 256.0);
        return (s >= 0.0) ? $rtoi(s + 0.5) : -$rtoi(-s + 0.5);
    endfunction

    // driver: one enabled sample, reference loop pushes the expected item
    task automatic drive_sample(input logic [15:0] f, input string tag);
        exp_t it;
        int   x;
        int   v;
        int   y;
        @(negedge clk);
        en  = 1'b1;
        fcw = f;
        x = m_acc >>> 4;
        v = x + 4 * m_err[0] - 6 * m_err[1] + 4 * m_err[2] - m_err[3];
        y = v >>> 4;
        m_err[3] = m_err[2];
        m_err[2] = m_err[1];
        m_err[1] = m_err[0];
        m_err[0] = v - 16 * y;
        it.addr = y & 255;
        it.x    = x;
        it.tag  = tag;
        sb.push_back(it);
        m_acc = (m_acc + int'(f)) & 16'hFFFF;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            en = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        en  = 1'b0;
        idle(3);
        rst = 1'b0;
        m_acc = 0;
        for (int i = 0; i < 4; i++) m_err[i] = 0;
        sb.delete();
        @(negedge clk);
        check(amp_valid == 1'b0, "R1", "valid after reset", int'(amp_valid), 0);
    endtask

    // monitor: pops and compares each produced sample
    always @(negedge clk) begin
        if (!rst && amp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R7", "unexpected output", 1, 0);
            end else begin
                exp_t it;
                int   d;
                int   ra;
                it = sb.pop_front();
                check(int'(phase_out) == it.addr, "R2 R3", "shaped phase",
                      int'(phase_out), it.addr);
                ra = ref_amp(int'(phase_out));
                check(int'(amp_out) - ra <= 1 && ra - int'(amp_out) <= 1, "R6",
                      "amplitude", int'(amp_out), ra);
                d = (16 * int'(phase_out) - it.x) & 12'hFFF;
                if (d >= 2048) d -= 4096;
                check(d >= -120 && d <= 120, "R5", "phase error", d, 0);
                if (track_mean) begin
                    mean_sum += d;
                    mean_n++;
                end
                if (it.tag == "R1") begin
                    check(phase_out == 8'd0 && amp_out == 12'sd0, "R1",
                          "first sample after reset", int'(amp_out), 0);
                end
                if (it.tag == "R8") begin
                    check(phase_out == 8'd0 && amp_out == 12'sd0, "R8",
                          "zero word output", int'(amp_out), 0);
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state and first sample
        do_reset();
        drive_sample(16'h1234, "R1");
        idle(5);

        // R7: single enable pulse latency
        drive_sample(16'h0400, "");
        @(negedge clk);
        en = 1'b0;
        check(amp_valid == 1'b0, "R7", "valid after edge k", int'(amp_valid), 0);
        @(negedge clk);
        check(amp_valid == 1'b0, "R7", "valid after edge k+1", int'(amp_valid), 0);
        @(negedge clk);
        check(amp_valid == 1'b1, "R7", "valid after edge k+2", int'(amp_valid), 1);
        @(negedge clk);
        check(amp_valid == 1'b0, "R7", "valid after edge k+3", int'(amp_valid), 0);
        idle(3);

        // R8: zero frequency word from a zero-phase start
        do_reset();
        for (int i = 0; i < 40; i++) drive_sample(16'h0000, "R8");
        idle(5);

        // R4, R7: long run with enable gaps, mean tracking
        do_reset();
        track_mean = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            drive_sample(16'h0123, "");
            if (i % 7 == 6) idle(1 + (i % 3));
        end
        idle(5);
        track_mean = 1'b0;
        check(mean_n == 3000, "R7", "output count", mean_n, 3000);
        check(4 * (mean_sum < 0 ? -mean_sum : mean_sum) < longint'(mean_n), "R4",
              "mean phase error x1000", int'((mean_sum * 1000) / (mean_n > 0 ? mean_n : 1)), 0);

        // R2: wrap cases and a one-LSB step
        for (int i = 0; i < 500; i++) drive_sample(16'hFFF0, "");
        for (int i = 0; i < 500; i++) drive_sample(16'h8001, "");
        for (int i = 0; i < 300; i++) drive_sample(16'h0010, "");
        for (int i = 0; i < 200; i++) drive_sample(16'h2AAB, "");
        idle(6);
        check(sb.size() == 0, "R7", "pending outputs", sb.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule